// File: doc/BRIEF.md
# Power-on self-test sequencer

This block controls a fixed chain of built-in tests that runs once after reset. It does not contain the tests. It gives each of four external sub-testers a one-cycle start pulse and waits for that tester's done or fail flag. The testers are taken in a fixed order: the checksum of the boot ROM region, a check of the bus-interface registers, the RAM tests, and the checksum pass over all ROMs.

Results appear on discrete LEDs, not on a display. The first failure stops the chain. A failure in the first two stages lights a steady LED reserved for that stage. A failure in RAM or ROM sends the failing device number as a repeating train of pulses on a shared code LED. When every stage passes, the block stays in a finished state and never hands over to normal operation. The self-test runs only if the test-select input is high while reset is applied.

Top module: `post_selftest`

## Requirements
- R1: Stage i is started by a one-cycle pulse on bit i of `stg_start`. The bit-to-stage mapping is 0 = boot ROM checksum, 1 = bus interface, 2 = RAM, 3 = all ROMs. Stage 0 starts in the first cycle after reset is released. Each later stage starts in the cycle after the current stage's done is sampled. At most one start bit is high at any time.
- R2: `test_sel` is sampled while `rst` is high. If it was low, no start is ever issued and every output stays low.
- R3: A stage-0 fail turns `led_boot` on steadily from the next cycle, and no further start is issued.
- R4: A stage-1 fail turns `led_bus` on steadily from the next cycle, and no further start is issued.
- R5: A stage-1 done (pass) raises `in_progress` from the next cycle. It stays high until reset.
- R6: A stage-2 or stage-3 fail with `fail_idx` = N makes `led_code` give N+1 pulses per train, and no further start is issued. Each pulse is high for PULSE_CYC cycles, and pulses within a train are separated by PULSE_CYC low cycles. The first pulse rises two cycles after the fail is sampled.
- R7: After the last pulse of a train, `led_code` stays low for GAP_CYC cycles. The train then repeats without end.
- R8: A stage-3 done raises `all_pass` from the next cycle. After that no start is issued, all LEDs stay off, and `all_pass` stays high.
- R9: Done and fail flags of stages other than the one being waited on have no effect. If done and fail of the current stage arrive in the same cycle, the fail wins.
- R10: The synchronous reset clears every output in the cycle after the reset edge and returns the sequencer to idle. This holds even in the middle of a halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_sel | input | 1 | Self-test enable, sampled during reset |
| stg_done | input | 4 | Per-stage pass flag |
| stg_fail | input | 4 | Per-stage fail flag |
| fail_idx | input | IDX_W | Failing device number, valid with a RAM/ROM fail |
| stg_start | output | 4 | One-cycle start pulse per stage |
| led_boot | output | 1 | Steady boot-ROM failure LED |
| led_bus | output | 1 | Steady bus-interface failure LED |
| led_code | output | 1 | Pulse-coded RAM/ROM failure LED |
| in_progress | output | 1 | Test-in-progress flag |
| all_pass | output | 1 | Set when every stage has passed |

## Verification
A start bit, a steady LED, `in_progress` and `all_pass` all appear one cycle after the sampled event, because each is a single register away from it. The code LED passes through one more register in the pulse generator, so its first pulse is due two cycles after the fail. The bench drives each response on a falling edge, waits one falling edge, and samples there. It then measures every high and low run of the code LED cycle by cycle against PULSE_CYC and GAP_CYC. It also confirms the idle gap of one cycle before the first pulse.

// File: rtl/post_pkg.sv
package post_pkg;
  localparam int NUM_STAGES = 4;
  localparam int STG_W      = $clog2(NUM_STAGES);

  localparam logic [STG_W-1:0] STG_BOOT = 2'd0;
  localparam logic [STG_W-1:0] STG_BUS  = 2'd1;
  localparam logic [STG_W-1:0] STG_RAM  = 2'd2;
  localparam logic [STG_W-1:0] STG_ROM  = 2'd3;
  localparam logic [STG_W-1:0] STG_LAST = STG_ROM;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WAIT,
    SQ_HALT_BOOT,
    SQ_HALT_BUS,
    SQ_HALT_CODE,
    SQ_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ON,
    PH_OFF,
    PH_GAP
  } phase_t;
endpackage

// File: rtl/post_seq_fsm.sv
module post_seq_fsm
  import post_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int CNT_W = IDX_W + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  test_sel,
  input  logic [NUM_STAGES-1:0] stg_done,
  input  logic [NUM_STAGES-1:0] stg_fail,
  input  logic [IDX_W-1:0]      fail_idx,
  output logic [NUM_STAGES-1:0] stg_start,
  output logic                  led_boot,
  output logic                  led_bus,
  output logic                  in_progress,
  output logic                  all_pass,
  output logic                  code_en,
  output logic [CNT_W-1:0]      code_cnt
);
  seq_state_t       state;
  logic [STG_W-1:0] stage;
  logic [STG_W-1:0] stage_nxt;
  logic             sel_q;

  assign stage_nxt = stage + 1'b1;
  assign code_en   = (state == SQ_HALT_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_IDLE;
      stage       <= STG_BOOT;
      sel_q       <= test_sel;
      stg_start   <= '0;
      led_boot    <= 1'b0;
      led_bus     <= 1'b0;
      in_progress <= 1'b0;
      all_pass    <= 1'b0;
      code_cnt    <= '0;
    end else begin
      stg_start <= '0;
      case (state)
        SQ_IDLE: begin
          if (sel_q) begin
            state     <= SQ_WAIT;
            stage     <= STG_BOOT;
            stg_start <= NUM_STAGES'(1);
          end
        end
        SQ_WAIT: begin
          if (stg_fail[stage]) begin
            case (stage)
              STG_BOOT: begin
                state    <= SQ_HALT_BOOT;
                led_boot <= 1'b1;
              end
              STG_BUS: begin
                state   <= SQ_HALT_BUS;
                led_bus <= 1'b1;
              end
              default: begin
                state    <= SQ_HALT_CODE;
                code_cnt <= CNT_W'(fail_idx) + CNT_W'(1);
              end
            endcase
          end else if (stg_done[stage]) begin
            if (stage == STG_BUS) in_progress <= 1'b1;
            if (stage == STG_LAST) begin
              state    <= SQ_DONE;
              all_pass <= 1'b1;
            end else begin
              stage     <= stage_nxt;
              stg_start <= NUM_STAGES'(1) << stage_nxt;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stg_start)); // R1
  AST_NOSEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    !sel_q |-> (stg_start == '0 && !led_boot && !led_bus && !all_pass)); // R2
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (led_boot || led_bus || code_en || all_pass) |=> stg_start == '0); // R3
  AST_BOOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    led_boot |=> led_boot); // R3
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    led_bus |=> led_bus); // R4
  AST_PROG_HOLD: assert property (@(posedge clk) disable iff (rst)
    in_progress |=> in_progress); // R5
  AST_PASS_HOLD: assert property (@(posedge clk) disable iff (rst)
    all_pass |=> (all_pass && !led_boot && !led_bus)); // R8
endmodule

// File: rtl/post_pulse_gen.sv
module post_pulse_gen
  import post_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int PULSE_CYC = 4,
  parameter int GAP_CYC   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] count,
  output logic             led
);
  localparam int TMAX = (GAP_CYC > PULSE_CYC) ? GAP_CYC : PULSE_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] PULSE_LAST = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] GAP_LAST   = TW'(GAP_CYC - 1);

  phase_t           phase;
  logic [TW-1:0]    tcnt;
  logic [CNT_W-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase <= PH_IDLE;
      tcnt  <= '0;
      pcnt  <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          phase <= PH_ON;
          tcnt  <= '0;
          pcnt  <= CNT_W'(1);
        end
        PH_ON: begin
          if (tcnt == PULSE_LAST) begin
            tcnt  <= '0;
            phase <= (pcnt >= count) ? PH_GAP : PH_OFF;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        PH_OFF: begin
          if (tcnt == PULSE_LAST) begin
            tcnt  <= '0;
            pcnt  <= pcnt + 1'b1;
            phase <= PH_ON;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: begin
          if (tcnt == GAP_LAST) begin
            tcnt  <= '0;
            pcnt  <= CNT_W'(1);
            phase <= PH_ON;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign led = (phase == PH_ON);

  AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> !led); // R6
  AST_PCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (en && phase != PH_IDLE) |-> (pcnt >= CNT_W'(1) && pcnt <= count)); // R6
  AST_GAP_TO_ON: assert property (@(posedge clk) disable iff (rst)
    (en && phase == PH_GAP && tcnt == GAP_LAST) |=> led); // R7
endmodule

// File: rtl/post_selftest.sv
module post_selftest
  import post_pkg::*;
#(
  parameter int IDX_W     = 5,
  parameter int PULSE_CYC = 50_000_000,
  parameter int GAP_CYC   = 200_000_000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  test_sel,
  input  logic [NUM_STAGES-1:0] stg_done,
  input  logic [NUM_STAGES-1:0] stg_fail,
  input  logic [IDX_W-1:0]      fail_idx,
  output logic [NUM_STAGES-1:0] stg_start,
  output logic                  led_boot,
  output logic                  led_bus,
  output logic                  led_code,
  output logic                  in_progress,
  output logic                  all_pass
);
  localparam int CNT_W = IDX_W + 1;

  logic             code_en;
  logic [CNT_W-1:0] code_cnt;

  post_seq_fsm #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .test_sel(test_sel),
    .stg_done(stg_done), .stg_fail(stg_fail), .fail_idx(fail_idx),
    .stg_start(stg_start), .led_boot(led_boot), .led_bus(led_bus),
    .in_progress(in_progress), .all_pass(all_pass),
    .code_en(code_en), .code_cnt(code_cnt)
  );

  post_pulse_gen #(.CNT_W(CNT_W), .PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC)) u_pulse (
    .clk(clk), .rst(rst), .en(code_en), .count(code_cnt), .led(led_code)
  );

  AST_CODE_EXCL: assert property (@(posedge clk) disable iff (rst)
    led_code |-> (!led_boot && !led_bus && !all_pass && stg_start == '0)); // R6
endmodule

// File: tb/tb_post_selftest.sv
`timescale 1ns/1ps
module tb_post_selftest;
  localparam int IDX_W = 5;
  localparam int PULSE = 3;
  localparam int GAP   = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             test_sel = 1'b0;
  logic [3:0]       stg_done = '0;
  logic [3:0]       stg_fail = '0;
  logic [IDX_W-1:0] fail_idx = '0;
  logic [3:0]       stg_start;
  logic             led_boot, led_bus, led_code, in_progress, all_pass;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  post_selftest #(.IDX_W(IDX_W), .PULSE_CYC(PULSE), .GAP_CYC(GAP)) dut (
    .clk(clk), .rst(rst), .test_sel(test_sel),
    .stg_done(stg_done), .stg_fail(stg_fail), .fail_idx(fail_idx),
    .stg_start(stg_start), .led_boot(led_boot), .led_bus(led_bus),
    .led_code(led_code), .in_progress(in_progress), .all_pass(all_pass)
  );

  function automatic int exp_pulses(input int idx);
    return idx + 1;
  endfunction

  function automatic logic [3:0] exp_start(input int s);
    return 4'(1) << s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic sel);
    @(negedge clk);
    rst = 1'b1; test_sel = sel; stg_done = '0; stg_fail = '0;
    @(negedge clk);
    chk("R10 outputs cleared", {27'd0, stg_start, led_boot, led_bus, led_code, in_progress, all_pass}, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic count_train(output int np, output int badw, output int gap);
    int hi, lo;
    np = 0; badw = 0; gap = 0;
    for (int k = 0; k < 40; k++) begin
      hi = 0;
      while (led_code && hi < PULSE + 3) begin hi++; @(negedge clk); end
      if (hi != PULSE) badw++;
      np++;
      lo = 0;
      while (!led_code && lo < GAP + 3) begin lo++; @(negedge clk); end
      if (lo != PULSE) begin gap = lo; break; end
    end
  endtask

  task automatic check_train(input int idx);
    int lead, np, badw, gap;
    lead = 0;
    while (!led_code && lead < 6) begin lead++; @(negedge clk); end
    chk("R6 first pulse latency", lead, 1);
    count_train(np, badw, gap);
    chk("R6 pulse widths", badw, 0);
    chk("R6 pulse count", np, exp_pulses(idx));
    chk("R7 gap length", gap, GAP);
    count_train(np, badw, gap);
    chk("R7 repeated train count", np, exp_pulses(idx));
    chk("R7 repeated gap", gap, GAP);
  endtask

  // fstage: 0..3 fails that stage, 4 = all pass; both: done raised with fail (R9)
  task automatic run_seq(input int fstage, input int idx, input bit both);
    int d, bad;
    @(negedge clk);
    chk("R1 stage 0 start", stg_start, exp_start(0));
    for (int s = 0; s < 4; s++) begin
      d = $urandom % 4;
      bad = 0;
      for (int i = 0; i < d; i++) begin
        stg_done = 4'($urandom) & ~exp_start(s);
        stg_fail = 4'($urandom) & ~exp_start(s);
        fail_idx = IDX_W'($urandom);
        @(negedge clk);
        if (stg_start != 0) bad++;
      end
      chk("R9 foreign flags ignored", bad, 0);
      stg_done = 4'($urandom) & ~exp_start(s);
      stg_fail = 4'($urandom) & ~exp_start(s);
      if (s == fstage) begin
        stg_fail[s] = 1'b1;
        stg_done[s] = both;
        fail_idx = IDX_W'(idx);
      end else begin
        stg_done[s] = 1'b1;
      end
      @(negedge clk);
      stg_done = '0; stg_fail = '0;
      if (s == fstage) begin
        if (s == 0) chk("R3 boot LED", {led_boot, led_bus, led_code}, 4);
        if (s == 1) chk("R4 bus LED", {led_boot, led_bus, led_code}, 2);
        if (s >= 2) begin
          chk("R6 steady LEDs off", {led_boot, led_bus}, 0);
          check_train(idx);
        end
        break;
      end
      if (s == 0) chk("R5 no progress before bus pass", in_progress, 0);
      if (s == 1) chk("R5 progress flag", in_progress, 1);
      if (s < 3) chk("R1 next stage start", stg_start, exp_start(s + 1));
      else chk("R8 all pass", {all_pass, led_boot, led_bus, led_code}, 8);
    end
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      stg_done = 4'($urandom); stg_fail = 4'($urandom);
      @(negedge clk);
      if (stg_start != 0) bad++;
      if (fstage == 0 && !led_boot) bad++;
      if (fstage == 1 && !led_bus) bad++;
      if (fstage == 4 && (!all_pass || led_code || led_boot || led_bus)) bad++;
    end
    stg_done = '0; stg_fail = '0;
    chk(fstage == 0 ? "R3 halt holds" : fstage == 1 ? "R4 halt holds" :
        fstage == 4 ? "R8 done holds" : "R6 halt holds", bad, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int bad, fs, ix;
    void'($urandom(32'h5EED_0042));
    // R2: test_sel low at reset
    do_reset(1'b0);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      stg_done = 4'($urandom); stg_fail = 4'($urandom);
      @(negedge clk);
      if ({stg_start, led_boot, led_bus, led_code, in_progress, all_pass} != 0) bad++;
    end
    stg_done = '0; stg_fail = '0;
    chk("R2 no self-test without select", bad, 0);

    do_reset(1'b1); run_seq(4, 0, 1'b0);
    do_reset(1'b1); run_seq(0, 0, 1'b0);
    do_reset(1'b1); run_seq(1, 0, 1'b1);
    do_reset(1'b1); run_seq(2, 0, 1'b0);
    do_reset(1'b1); run_seq(2, 2, 1'b1);
    do_reset(1'b1); run_seq(3, 3, 1'b0);
    do_reset(1'b1); run_seq(3, 17, 1'b0);
    do_reset(1'b1); run_seq(3, 31, 1'b1);
    for (int r = 0; r < 12; r++) begin
      fs = $urandom % 5;
      ix = (fs == 2) ? $urandom % 3 : $urandom % 18;
      do_reset(1'b1);
      run_seq(fs, ix, 1'($urandom));
    end
    do_reset(1'b0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule